// File: doc/BRIEF.md
# Multi-PHY FIFO Availability Poll Responder

This block is the receive-side status responder of one PHY port that shares a polled status line with other ports on a multi-PHY bus. A link-layer master places a 5-bit port address on a polling bus each clock. The port compares that address against its own assigned address. After a fixed latency it either drives the shared status line or releases it to high impedance. The release is modelled by an output-enable pin.

The status value depends on how full the receive FIFO is. In cell mode, the flag says that at least one complete 53-byte cell is buffered. In packet mode, it says that the buffered byte count has reached a programmable threshold. A level select picks the response latency: one clock in the short-latency mode, two clocks in the long-latency mode. The FIFO storage and the data read-out belong to neighbouring blocks.

All pins are plain control and status pins sampled on every clock. No data stream passes through the block, so no valid/ready handshake or back-pressure applies.

Top module: `mphy_poll_responder`

## Requirements
- R1: In cell mode (`pkt_mode`=0), while the line is driven, `avail` is 1 when the fill count sampled one clock earlier was 53 or more.
- R2: In cell mode, while the line is driven, `avail` is 0 when the fill count sampled one clock earlier was below 53, including an empty FIFO (count 0).
- R3: In packet mode (`pkt_mode`=1), while the line is driven, `avail` is 1 exactly when the fill count sampled one clock earlier is at least the threshold `byte_thresh` sampled on that same edge.
- R4: A `byte_thresh` of 0 behaves as a threshold of 1, so an empty FIFO reports 0 and a single byte reports 1.
- R5: With `level3`=0, `avail_oe` equals the result of the 5-bit comparison `poll_addr == my_addr` sampled on the previous clock edge.
- R6: With `level3`=1, `avail_oe` equals the result of that comparison sampled two clock edges earlier.
- R7: A poll of any other address brings `avail_oe` back to 0 with the same latency that a match uses to raise it, so only one port drives the line.
- R8: While `avail_oe` is 0, `avail` is 0.
- R9: A synchronous reset (`rst`=1) clears the address pipeline and the flag register, so `avail_oe` and `avail` are 0 on the edges after it. The address pipeline then refills without stale matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_count | input | 10 | Bytes currently held in the receive FIFO |
| pkt_mode | input | 1 | 0 = cell availability, 1 = packet availability |
| level3 | input | 1 | 0 = one-clock response, 1 = two-clock response |
| my_addr | input | 5 | Address assigned to this port |
| poll_addr | input | 5 | Address on the shared polling bus |
| byte_thresh | input | 10 | Packet-mode byte threshold (0 acts as 1) |
| avail | output | 1 | Status value for the shared line |
| avail_oe | output | 1 | Drive enable for the shared line (0 = high impedance) |

## Verification
The critical coincidence is a change of the enable and a change of the flag on the same edge. The bench first polls a foreign address while the FIFO crosses the cell or threshold boundary. It then returns to the port's own address exactly as the new fill value lands, so the first driven cycle must already show the new flag value. A second case switches `level3` while a match and a mismatch are both in flight in the pipeline. The enable must then follow the stage selected by the new level. Every cycle is compared against a reference model that is fed from the same stimulus and kept in a queue.

// File: rtl/mphy_poll_pkg.sv
package mphy_poll_pkg;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned CNT_W      = 10;
  localparam int unsigned CELL_BYTES = 53;
  localparam int unsigned MAX_LAT    = 2;

  typedef enum logic {
    FMT_CELL = 1'b0,
    FMT_PKT  = 1'b1
  } avail_fmt_e;
endpackage

// File: rtl/addr_match_pipe.sv
module addr_match_pipe
  import mphy_poll_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DEPTH = MAX_LAT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] poll_addr,
  input  logic [AW-1:0] my_addr,
  input  logic          level3,
  output logic          drive_en
);
  localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] hit_q;
  logic             hit_now;

  assign hit_now = (poll_addr == my_addr);

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) hit_q[0] <= 1'b0;
          else     hit_q[0] <= hit_now;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) hit_q[s] <= 1'b0;
          else     hit_q[s] <= hit_q[s-1];
        end
      end
    end
  endgenerate

  logic [SEL_W-1:0] tap;
  assign tap      = level3 ? SEL_W'(DEPTH - 1) : '0;
  assign drive_en = hit_q[tap];
endmodule

// File: rtl/avail_flag_gen.sv
module avail_flag_gen
  import mphy_poll_pkg::*;
#(
  parameter int unsigned CW   = CNT_W,
  parameter int unsigned CELL = CELL_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] fill_count,
  input  avail_fmt_e    fmt,
  input  logic [CW-1:0] byte_thresh,
  output logic          flag_q
);
  localparam logic [CW-1:0] CELL_LIM = CW'(CELL);

  logic [CW-1:0] pkt_lim;
  logic          flag_d;

  always_comb begin
    pkt_lim = (byte_thresh == '0) ? CW'(1) : byte_thresh;
    unique case (fmt)
      FMT_CELL: flag_d = (fill_count >= CELL_LIM);
      FMT_PKT:  flag_d = (fill_count >= pkt_lim);
      default:  flag_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end
endmodule

// File: rtl/mphy_poll_responder.sv
module mphy_poll_responder
  import mphy_poll_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned CW   = CNT_W,
  parameter int unsigned CELL = CELL_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] fill_count,
  input  logic          pkt_mode,
  input  logic          level3,
  input  logic [AW-1:0] my_addr,
  input  logic [AW-1:0] poll_addr,
  input  logic [CW-1:0] byte_thresh,
  output logic          avail,
  output logic          avail_oe
);
  avail_fmt_e fmt;
  logic       flag_q;
  logic       drive_en;

  assign fmt = pkt_mode ? FMT_PKT : FMT_CELL;

  addr_match_pipe #(.AW(AW), .DEPTH(MAX_LAT)) u_match (
    .clk       (clk),
    .rst       (rst),
    .poll_addr (poll_addr),
    .my_addr   (my_addr),
    .level3    (level3),
    .drive_en  (drive_en)
  );

  avail_flag_gen #(.CW(CW), .CELL(CELL)) u_flag (
    .clk         (clk),
    .rst         (rst),
    .fill_count  (fill_count),
    .fmt         (fmt),
    .byte_thresh (byte_thresh),
    .flag_q      (flag_q)
  );

  assign avail_oe = drive_en;
  assign avail    = drive_en & flag_q;
endmodule

// File: rtl/mphy_poll_chk.sv
module mphy_poll_chk #(
  parameter int unsigned AW   = 5,
  parameter int unsigned CW   = 10,
  parameter int unsigned CELL = 53
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] fill_count,
  input logic          pkt_mode,
  input logic          level3,
  input logic [AW-1:0] my_addr,
  input logic [AW-1:0] poll_addr,
  input logic [CW-1:0] byte_thresh,
  input logic          avail,
  input logic          avail_oe
);
  logic [1:0] since_rst;
  logic       hit;

  assign hit = (poll_addr == my_addr);

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r5_short_latency: assert property (@(posedge clk) disable iff (rst)
    (!level3 && since_rst >= 2'd1) |-> (avail_oe == $past(hit)));

  a_r6_long_latency: assert property (@(posedge clk) disable iff (rst)
    (level3 && since_rst >= 2'd2) |-> (avail_oe == $past(hit, 2)));

  a_r7_release_short: assert property (@(posedge clk) disable iff (rst)
    (!level3 && !hit) |=> (level3 || !avail_oe));

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !avail_oe |-> !avail);

  a_r1_r2_cell_flag: assert property (@(posedge clk) disable iff (rst)
    (avail_oe && since_rst >= 2'd1 && !$past(pkt_mode))
      |-> (avail == ($past(fill_count) >= CW'(CELL))));

  a_r3_r4_pkt_flag: assert property (@(posedge clk) disable iff (rst)
    (avail_oe && since_rst >= 2'd1 && $past(pkt_mode))
      |-> (avail == ($past(fill_count) >=
             (($past(byte_thresh) == '0) ? CW'(1) : $past(byte_thresh)))));

  a_r9_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!avail_oe && !avail));
endmodule

bind mphy_poll_responder mphy_poll_chk #(.AW(AW), .CW(CW), .CELL(CELL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fill_count  (fill_count),
  .pkt_mode    (pkt_mode),
  .level3      (level3),
  .my_addr     (my_addr),
  .poll_addr   (poll_addr),
  .byte_thresh (byte_thresh),
  .avail       (avail),
  .avail_oe    (avail_oe)
);

// File: tb/test_mphy_poll_responder.sv
module test_mphy_poll_responder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] fill_count = '0;
  logic       pkt_mode = 1'b0;
  logic       level3 = 1'b0;
  logic [4:0] my_addr = 5'd9;
  logic [4:0] poll_addr = 5'd0;
  logic [9:0] byte_thresh = '0;
  logic       avail;
  logic       avail_oe;

  always #2.5 clk = ~clk;

  mphy_poll_responder i_mphy_poll_responder (
    .clk(clk), .rst(rst), .fill_count(fill_count), .pkt_mode(pkt_mode),
    .level3(level3), .my_addr(my_addr), .poll_addr(poll_addr),
    .byte_thresh(byte_thresh), .avail(avail), .avail_oe(avail_oe)
  );

  typedef struct {
    logic  oe;
    logic  av;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // reference model state
  logic m_hit1 = 1'b0, m_hit2 = 1'b0, m_flag = 1'b0;
  bit   have_prev = 1'b0;

  task automatic apply(input logic r, input logic [4:0] pa, input logic [9:0] fc,
                       input logic pm, input logic l3, input logic [9:0] th,
                       input string tag);
    exp_t e;
    logic [9:0] lim;
    @(posedge clk);
    #1;
    // update model with inputs sampled at this edge
    if (rst) begin
      m_hit1 = 1'b0; m_hit2 = 1'b0; m_flag = 1'b0;
    end else begin
      m_hit2 = m_hit1;
      m_hit1 = (poll_addr == my_addr);
      lim    = (byte_thresh == 10'd0) ? 10'd1 : byte_thresh;
      m_flag = pkt_mode ? (fill_count >= lim) : (fill_count >= 10'd53);
    end
    rst = r; poll_addr = pa; fill_count = fc; pkt_mode = pm; level3 = l3;
    byte_thresh = th;
    if (have_prev) begin
      e.oe  = level3 ? m_hit2 : m_hit1;
      e.av  = e.oe & m_flag;
      e.tag = tag;
      exp_q.push_back(e);
    end
    have_prev = 1'b1;
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_vec++;
        if (avail_oe !== e.oe || avail !== e.av) begin
          n_bad++;
          $display("FAIL %s: oe=%b avail=%b expected oe=%b avail=%b at %0t",
                   e.tag, avail_oe, avail, e.oe, e.av, $time);
        end
      end
    end
  end

  initial begin
    fork
      begin
        // R9: reset state
        apply(1, 9, 600, 0, 0, 0, "R9");
        apply(1, 9, 600, 0, 0, 0, "R9");
        apply(0, 9, 0,   0, 0, 0, "R9");
        // R5 short latency, R2 cell low
        apply(0, 9, 0,   0, 0, 0, "R5");
        apply(0, 9, 52,  0, 0, 0, "R2");
        apply(0, 9, 53,  0, 0, 0, "R2");
        apply(0, 9, 1023,0, 0, 0, "R1");
        apply(0, 9, 53,  0, 0, 0, "R1");
        // R7 release, R8 quiet while off
        apply(0, 3, 200, 0, 0, 0, "R7");
        apply(0, 3, 200, 0, 0, 0, "R8");
        // coincidence: return to own address as fill drops
        apply(0, 9, 10,  0, 0, 0, "R8");
        apply(0, 9, 10,  0, 0, 0, "R2");
        apply(0, 9, 10,  0, 0, 0, "R2");
        // R6 long latency
        apply(0, 9, 60,  0, 1, 0, "R6");
        apply(0, 4, 60,  0, 1, 0, "R6");
        apply(0, 4, 60,  0, 1, 0, "R7");
        apply(0, 9, 60,  0, 1, 0, "R7");
        apply(0, 9, 60,  0, 1, 0, "R6");
        apply(0, 9, 60,  0, 1, 0, "R6");
        // level switch with mixed pipeline
        apply(0, 1, 60,  0, 1, 0, "R6");
        apply(0, 9, 60,  0, 0, 0, "R5");
        apply(0, 9, 60,  0, 1, 0, "R6");
        apply(0, 9, 60,  0, 0, 0, "R5");
        // R3 packet threshold
        apply(0, 9, 99,  1, 0, 100, "R3");
        apply(0, 9, 100, 1, 0, 100, "R3");
        apply(0, 9, 101, 1, 0, 100, "R3");
        apply(0, 9, 40,  1, 0, 100, "R3");
        apply(0, 9, 40,  1, 0, 30,  "R3");
        // R4 zero threshold
        apply(0, 9, 0,   1, 0, 0, "R3");
        apply(0, 9, 1,   1, 0, 0, "R4");
        apply(0, 9, 0,   1, 0, 0, "R4");
        apply(0, 9, 0,   1, 1, 0, "R4");
        // R9 mid-run reset
        apply(1, 9, 500, 0, 1, 0, "R4");
        apply(0, 9, 500, 0, 1, 0, "R9");
        apply(0, 9, 500, 0, 1, 0, "R9");
        apply(0, 9, 500, 0, 1, 0, "R9");
        apply(0, 9, 500, 0, 1, 0, "R1");
        apply(0, 9, 500, 0, 1, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_bad++;
          $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule